// File: doc/BRIEF.md
# Serial Receiver with Error-Tagged Receive Queue

This block receives asynchronous serial characters on one line. It runs on a single system clock. It moves forward only on cycles where a clock-enable strobe is high, and that strobe pulses at sixteen times the bit rate. The line input is first brought into the clock domain and then cleaned by a three-sample majority filter. A falling edge opens a candidate start bit. The receiver samples the line again half a bit later to confirm it. From there each data bit, an optional parity bit and the stop bit are sampled at mid-bit.

Every finished character enters a 16-entry queue together with three error tags: parity, framing and break. The host sees the oldest character and its tags on the outputs and removes it with a pop strobe. A level interrupt is raised once the queue holds at least the number of characters chosen by a 2-bit threshold code. A summary error flag stays high while any stored character carries a tag. A sticky overrun flag records a character that arrived while the queue was full.

Top module: `serial_rx_queue`

## Requirements
- R1: After reset the queue is empty: `rx_ready`, `lvl_irq`, `overrun`, `err_any` and all head tags are low.
- R2: A frame is a low start bit, then 8 data bits least significant bit first, then an optional parity bit and a stop bit. Each bit lasts 16 `tick` pulses. The received byte appears on `rd_data` and `rx_ready` rises.
- R3: With `par_en` high a parity bit follows the data. With `par_even`=1 the data ones plus the parity bit must be even in count; with `par_even`=0 they must be odd. A mismatch sets `err_par` for that character.
- R4: A stop bit sampled low sets `err_frm` for that character.
- R5: A character whose data bits, parity bit (if present) and stop bit are all sampled low sets `err_brk` (together with `err_frm`). The receiver then waits for the line to return high before it looks for another start bit, so a held-low line yields one character.
- R6: The start bit is sampled again 8 ticks after the falling edge is seen. If the line is high there, nothing is stored and the receiver returns to idle.
- R7: The queue holds 16 characters in arrival order. A `pop` pulse while it is non-empty removes the head character.
- R8: `lvl_irq` is high exactly when the stored count is at least the threshold picked by `thr_sel`: 00→1, 01→4, 10→8, 11→14.
- R9: `err_par`, `err_frm` and `err_brk` describe the head character and are low while the queue is empty.
- R10: `err_any` is high while at least one stored character has any tag set.
- R11: A character that completes while 16 are stored is discarded and the queue contents are unchanged. `overrun` goes high and stays high until an `ack_ovr` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Asynchronous reset, active high |
| tick | input | 1 | Receive enable, 16 pulses per bit |
| rxd | input | 1 | Serial line, idle high |
| par_en | input | 1 | Parity bit present |
| par_even | input | 1 | 1 = even parity, 0 = odd |
| thr_sel | input | 2 | Interrupt fill threshold code |
| pop | input | 1 | Remove the head character |
| ack_ovr | input | 1 | Clear the overrun flag |
| rd_data | output | 8 | Head character |
| rx_ready | output | 1 | Queue non-empty |
| lvl_irq | output | 1 | Fill level at or above threshold |
| err_par | output | 1 | Head parity error |
| err_frm | output | 1 | Head framing error |
| err_brk | output | 1 | Head break indication |
| err_any | output | 1 | Some stored character is tagged |
| overrun | output | 1 | Sticky overrun flag |

## Verification
The hardest state to reach is a full queue that receives one more character. That character must be dropped while the 16 stored entries stay intact. The stimulus fills the queue frame by frame without popping and checks the interrupt against all four threshold codes at every fill level on the way. It then sends a seventeenth, distinctive byte and drains the queue to show that the first sixteen bytes come out in order and the extra byte never appears. A held-low break line and a short start glitch are driven as separate waveforms to reach the hold-for-idle and abort paths.

// File: rtl/serial_rx_queue.sv
module serial_rx_queue #(
  parameter int DEPTH = 16,
  parameter int OVS   = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       rxd,
  input  logic       par_en,
  input  logic       par_even,
  input  logic [1:0] thr_sel,
  input  logic       pop,
  input  logic       ack_ovr,
  output logic [7:0] rd_data,
  output logic       rx_ready,
  output logic       lvl_irq,
  output logic       err_par,
  output logic       err_frm,
  output logic       err_brk,
  output logic       err_any,
  output logic       overrun
);
  localparam int AW   = $clog2(DEPTH);
  localparam int CW   = $clog2(OVS);
  localparam int EW   = 11;
  localparam logic [CW-1:0] MID_START = CW'(OVS / 2 - 1);
  localparam logic [CW-1:0] BIT_END   = CW'(OVS - 1);
  localparam logic [AW:0]   LV_FULL   = (AW + 1)'(DEPTH);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_HOLD} rx_state_t;

  logic [1:0]    sy;
  logic [2:0]    hist;
  logic          filt;
  rx_state_t     st;
  logic [CW-1:0] cnt;
  logic [2:0]    nbit;
  logic [7:0]    shf;
  logic          pbit, stopb, pen_l, pev_l, done;

  always_ff @(posedge clk or posedge rst)
    if (rst) begin
      sy   <= 2'b11;
      hist <= 3'b111;
    end else begin
      sy <= {sy[0], rxd};
      if (tick) hist <= {hist[1:0], sy[1]};
    end

  assign filt = (hist[0] & hist[1]) | (hist[1] & hist[2]) | (hist[0] & hist[2]);

  always_ff @(posedge clk or posedge rst)
    if (rst) begin
      st    <= S_IDLE;
      cnt   <= '0;
      nbit  <= '0;
      shf   <= '0;
      pbit  <= 1'b0;
      stopb <= 1'b1;
      pen_l <= 1'b0;
      pev_l <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (tick) begin
        case (st)
          S_IDLE:
            if (!filt) begin
              st  <= S_START;
              cnt <= '0;
            end
          S_START:
            if (cnt == MID_START) begin
              cnt <= '0;
              if (!filt) begin
                st    <= S_DATA;
                nbit  <= '0;
                pbit  <= 1'b0;
                pen_l <= par_en;
                pev_l <= par_even;
              end else begin
                st <= S_IDLE;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          S_DATA:
            if (cnt == BIT_END) begin
              cnt  <= '0;
              shf  <= {filt, shf[7:1]};
              nbit <= nbit + 1'b1;
              if (nbit == 3'd7) st <= pen_l ? S_PAR : S_STOP;
            end else begin
              cnt <= cnt + 1'b1;
            end
          S_PAR:
            if (cnt == BIT_END) begin
              cnt  <= '0;
              pbit <= filt;
              st   <= S_STOP;
            end else begin
              cnt <= cnt + 1'b1;
            end
          S_STOP:
            if (cnt == BIT_END) begin
              cnt   <= '0;
              stopb <= filt;
              done  <= 1'b1;
              st    <= filt ? S_IDLE : S_HOLD;
            end else begin
              cnt <= cnt + 1'b1;
            end
          S_HOLD:
            if (filt) st <= S_IDLE;
          default: st <= S_IDLE;
        endcase
      end
    end

  logic          new_pe, new_fe, new_brk;
  logic [EW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   lvl, errcnt, thr;
  logic [EW-1:0] head;
  logic          full, push, popv, push_bad, pop_bad;

  assign new_pe  = pen_l & (pbit != (^shf ^ ~pev_l));
  assign new_fe  = ~stopb;
  assign new_brk = ~stopb & (shf == 8'h00) & ~(pen_l & pbit);

  assign full = (lvl == LV_FULL);
  assign push = done & ~full;
  assign popv = pop & (lvl != '0);
  assign head = mem[rp];

  assign push_bad = push & (new_pe | new_fe | new_brk);
  assign pop_bad  = popv & (|head[10:8]);

  always_ff @(posedge clk)
    if (push) mem[wp] <= {new_brk, new_fe, new_pe, shf};

  always_ff @(posedge clk or posedge rst)
    if (rst) begin
      wp      <= '0;
      rp      <= '0;
      lvl     <= '0;
      errcnt  <= '0;
      overrun <= 1'b0;
    end else begin
      if (push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (popv) rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      lvl    <= lvl + (AW + 1)'(push) - (AW + 1)'(popv);
      errcnt <= errcnt + (AW + 1)'(push_bad) - (AW + 1)'(pop_bad);
      if (done && full) overrun <= 1'b1;
      else if (ack_ovr) overrun <= 1'b0;
    end

  always_comb
    case (thr_sel)
      2'd0:    thr = (AW + 1)'(1);
      2'd1:    thr = (AW + 1)'(4);
      2'd2:    thr = (AW + 1)'(8);
      default: thr = (AW + 1)'(14);
    endcase

  assign rx_ready = (lvl != '0);
  assign lvl_irq  = (lvl >= thr);
  assign rd_data  = head[7:0];
  assign err_par  = rx_ready & head[8];
  assign err_frm  = rx_ready & head[9];
  assign err_brk  = rx_ready & head[10];
  assign err_any  = (errcnt != '0);
endmodule

// File: rtl/serial_rx_queue_chk.sv
module serial_rx_queue_chk (
  input logic clk,
  input logic rst,
  input logic ack_ovr,
  input logic rx_ready,
  input logic lvl_irq,
  input logic err_par,
  input logic err_frm,
  input logic err_brk,
  input logic err_any,
  input logic overrun
);
  a_r1_reset_empty: assert property (@(posedge clk)
    $fell(rst) |-> (!rx_ready && !overrun && !err_any));

  a_r9_empty_no_tags: assert property (@(posedge clk) disable iff (rst)
    !rx_ready |-> !(err_par || err_frm || err_brk));

  a_r8_irq_needs_data: assert property (@(posedge clk) disable iff (rst)
    lvl_irq |-> rx_ready);

  a_r10_any_covers_head: assert property (@(posedge clk) disable iff (rst)
    (err_par || err_frm || err_brk) |-> err_any);

  a_r5_break_is_framing: assert property (@(posedge clk) disable iff (rst)
    err_brk |-> err_frm);

  a_r11_overrun_sticky: assert property (@(posedge clk) disable iff (rst)
    (overrun && !ack_ovr) |=> overrun);
endmodule

bind serial_rx_queue serial_rx_queue_chk u_chk (.*);

// File: tb/sim_serial_rx_queue.sv
module sim_serial_rx_queue;
  logic       clk = 1'b0, rst = 1'b1, tk = 1'b0, rxd = 1'b1;
  logic       par_en = 1'b0, par_even = 1'b0, pop = 1'b0, ack_ovr = 1'b0;
  logic [1:0] thr_sel = 2'd0;
  logic [7:0] rd_data;
  logic       rx_ready, lvl_irq, err_par, err_frm, err_brk, err_any, overrun;
  int n_vec = 0, n_bad = 0;

  serial_rx_queue u0 (
    .clk(clk), .rst(rst), .tick(tk), .rxd(rxd), .par_en(par_en), .par_even(par_even),
    .thr_sel(thr_sel), .pop(pop), .ack_ovr(ack_ovr), .rd_data(rd_data),
    .rx_ready(rx_ready), .lvl_irq(lvl_irq), .err_par(err_par), .err_frm(err_frm),
    .err_brk(err_brk), .err_any(err_any), .overrun(overrun));

  always #10 clk = ~clk;
  always @(posedge clk) tk <= ~tk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      while (!tk) @(posedge clk);
    end
  endtask

  task automatic drive_bit(input logic v, input int n);
    @(negedge clk);
    rxd = v;
    wait_ticks(n);
  endtask

  task automatic send(input logic [7:0] d, input logic bad_par, input logic stop_v, input int extra_low);
    logic p;
    p = par_even ? ^d : ~^d;
    if (bad_par) p = ~p;
    drive_bit(1'b0, 16);
    for (int i = 0; i < 8; i++) drive_bit(d[i], 16);
    if (par_en) drive_bit(p, 16);
    drive_bit(stop_v, 16 + extra_low);
    drive_bit(1'b1, 16);
    @(negedge clk);
  endtask

  task automatic do_pop();
    @(negedge clk) pop = 1'b1;
    @(negedge clk) pop = 1'b0;
  endtask

  function automatic int thr_of(input int s);
    return (s == 0) ? 1 : (s == 1) ? 4 : (s == 2) ? 8 : 14;
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 rx_ready", rx_ready, 0);
    check("R1 lvl_irq", lvl_irq, 0);
    check("R1 overrun", overrun, 0);
    check("R1 err_any", err_any, 0);
    check("R9 tags empty", {err_par, err_frm, err_brk}, 0);

    // R2/R3 sweep over all bytes, three parity modes, injected parity faults
    for (int v = 0; v < 256; v++) begin
      logic bad;
      par_en   = (v % 3) != 0;
      par_even = (v % 3) == 1;
      bad = par_en && ((v % 16) == 5);
      send(v[7:0], bad, 1'b1, 0);
      check("R2 ready", rx_ready, 1);
      check("R2 data", rd_data, v);
      check("R3 parity tag", err_par, bad);
      check("R4 no framing", err_frm, 0);
      check("R10 any", err_any, bad);
      check("R8 irq thr1", lvl_irq, 1);
      do_pop();
      check("R7 drained", rx_ready, 0);
    end

    // R6 start glitch
    par_en = 1'b0;
    drive_bit(1'b0, 4);
    drive_bit(1'b1, 40);
    @(negedge clk);
    check("R6 glitch dropped", rx_ready, 0);

    // R9/R10 head tags follow the queue
    par_en = 1'b1; par_even = 1'b1;
    send(8'h11, 1'b0, 1'b1, 0);
    send(8'h22, 1'b1, 1'b1, 0);
    send(8'h33, 1'b0, 1'b0, 0);
    check("R9 head clean", {err_brk, err_frm, err_par}, 3'b000);
    check("R10 any set", err_any, 1);
    do_pop();
    check("R9 head data2", rd_data, 8'h22);
    check("R9 head par", {err_brk, err_frm, err_par}, 3'b001);
    do_pop();
    check("R4 head frm", {err_brk, err_frm, err_par}, 3'b010);
    check("R10 any still", err_any, 1);
    do_pop();
    check("R10 any clear", err_any, 0);
    check("R9 empty tags", {err_brk, err_frm, err_par}, 3'b000);

    // R5 break held low well past the frame
    par_en = 1'b0;
    send(8'h00, 1'b0, 1'b0, 60);
    check("R5 break tag", {err_brk, err_frm}, 2'b11);
    do_pop();
    check("R5 single char", rx_ready, 0);

    // R8 threshold at every level, then R11 overrun
    for (int k = 0; k < 16; k++) begin
      for (int s = 0; s < 4; s++) begin
        thr_sel = s[1:0];
        @(negedge clk);
        check("R8 irq level", lvl_irq, (k >= thr_of(s)) ? 1 : 0);
      end
      send(8'h40 + k[7:0], 1'b0, 1'b1, 0);
    end
    check("R11 no overrun yet", overrun, 0);
    send(8'hEE, 1'b0, 1'b1, 0);
    check("R11 overrun set", overrun, 1);
    for (int k = 0; k < 16; k++) begin
      check("R7/R11 order kept", rd_data, 8'h40 + k);
      do_pop();
    end
    check("R11 extra discarded", rx_ready, 0);
    check("R11 overrun sticky", overrun, 1);
    @(negedge clk) ack_ovr = 1'b1;
    @(negedge clk) ack_ovr = 1'b0;
    check("R11 overrun cleared", overrun, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule